// File: doc/BRIEF.md
# Iterative Bitonic Sorting Engine

This block sorts a local buffer of N words in place by running the full bitonic compare-exchange schedule. Software or a neighbouring block loads the buffer one word per cycle through an indexed write port and pulses start. The engine then steps through every merge stage and every halving distance inside each stage. It performs all compare-exchanges of one step in a single clock edge, so no step can read values that the previous step has not finished writing. When the last step is done it raises done for one cycle. The sorted words are then read back by index, one per cycle.

N is a power-of-two parameter, 16 by default and usable up to 256. Keys are W bits wide and compare as two's-complement when SIGNED is 1, or as unsigned when it is 0. The element at index i pairs with the element at index i XOR j, where j is the step distance. The lower index of each pair decides the order of the pair from bit log2(k) of its own index, where k is the stage size. When that bit is 0 the pair goes ascending; when it is 1 the pair goes descending. In the last stage every pair goes ascending.

Top module: `bitonic_sort_engine`

## Requirements
- R1: After reset busy_o and done_o are 0, and every buffer word reads as 0 on rd_data_o.
- R2: While idle, a cycle with wr_valid_i high stores wr_data_i at index wr_idx_i, and rd_data_o shows the word at rd_idx_i combinationally.
- R3: A start_i pulse while idle raises busy_o from the next clock edge, for exactly log2(N)*(log2(N)+1)/2 cycles (10 cycles at N=16). Stage size k runs 2, 4, ... N, and for each k the distance j runs k/2 down to 1.
- R4: done_o is high for exactly one cycle: the first cycle after busy_o falls.
- R5: After done_o the buffer holds the loaded words in ascending order: two's-complement order when SIGNED=1 and unsigned order when SIGNED=0. A pair is swapped only when the element that should come first is strictly greater.
- R6: The sorted result is a permutation of the loaded words, so duplicate keys are all kept, and a buffer of equal keys is left unchanged.
- R7: A start_i pulse while busy_o is high is ignored: the run length does not change, no second run follows, and the result is still correct.
- R8: wr_valid_i is ignored while busy_o is high, so the buffer contents are not changed by it.
- R9: While busy_o is high, rd_data_o reads 0 whatever rd_idx_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Load strobe for one buffer word |
| wr_idx_i | input | log2(N) | Index of the word to load |
| wr_data_i | input | W | Word to load |
| start_i | input | 1 | Begin a sort run (idle only) |
| rd_idx_i | input | log2(N) | Index of the word to read |
| rd_data_o | output | W | Word at rd_idx_i, 0 while busy |
| busy_o | output | 1 | Sort run in progress |
| done_o | output | 1 | One-cycle pulse after the final step |

## Verification
The bench sorts several kinds of vector and compares each against a reference sort it computes itself: random vectors, reversed vectors, vectors that are already sorted, vectors of all-equal keys, vectors heavy with duplicates, and vectors that mix the most negative and the most positive keys. A design that compared unsigned in signed mode would put the negative extremes last. A design that swapped equal keys, or took a wrong partner, would lose or duplicate words. A wrong direction bit would leave sorted runs that are not merged into one ascending list. The bench also counts the busy cycles and checks the done pulse, which catches a stage or distance loop that is off by one. It pulses start, writes and reads during a run to show that the engine ignores them and blocks the read port.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
  import bsort_pkg::*;
#(
  parameter int LOG = 4,
  parameter int SW  = $clog2(LOG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] stage_o,
  output logic [SW-1:0] dist_o
);
  ctrl_state_e   state_q;
  logic [SW-1:0] stage_q, dist_q;
  logic          done_q;

  // stage_q = log2(k), dist_q = log2(j)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stage_q <= SW'(1);
      dist_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            stage_q <= SW'(1);
            dist_q  <= '0;
          end
        end
        ST_RUN: begin
          if (dist_q == '0) begin
            if (stage_q == SW'(LOG)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              stage_q <= stage_q + SW'(1);
              dist_q  <= stage_q;
            end
          end else begin
            dist_q <= dist_q - SW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign stage_o = stage_q;
  assign dist_o  = dist_q;
endmodule

// File: rtl/bsort_stage.sv
module bsort_stage #(
  parameter int N      = 16,
  parameter int W      = 16,
  parameter bit SIGNED = 1'b1,
  parameter int IW     = $clog2(N),
  parameter int SW     = $clog2(IW + 1)
) (
  input  logic [N-1:0][W-1:0] data_i,
  input  logic [SW-1:0]       stage_i,
  input  logic [SW-1:0]       dist_i,
  output logic [N-1:0][W-1:0] data_o
);
  function automatic logic key_gt(input logic [W-1:0] a, input logic [W-1:0] b);
    if (SIGNED) return $signed(a) > $signed(b);
    else        return a > b;
  endfunction

  always_comb begin
    data_o = data_i;
    for (int i = 0; i < N; i++) begin
      logic [IW-1:0] ia, mask, pa;
      logic [W-1:0]  a, b;
      logic          desc, swap;
      ia   = IW'(i);
      mask = IW'(1) << dist_i;
      pa   = ia ^ mask;
      a    = data_i[ia];
      b    = data_i[pa];
      desc = |((ia >> stage_i) & IW'(1));
      swap = desc ? key_gt(b, a) : key_gt(a, b);
      if (((ia & mask) == '0) && swap) begin
        data_o[ia] = b;
        data_o[pa] = a;
      end
    end
  end
endmodule

// File: rtl/bitonic_sort_engine.sv
module bitonic_sort_engine #(
  parameter int N      = 16,
  parameter int W      = 16,
  parameter bit SIGNED = 1'b1,
  localparam int IW    = $clog2(N),
  localparam int SW    = $clog2(IW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          start_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [N-1:0][W-1:0] mem_q, net_w;
  logic [SW-1:0]       stage_w, dist_w;
  logic                busy_w;

  bsort_ctrl #(.LOG(IW), .SW(SW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_w),
    .done_o  (done_o),
    .stage_o (stage_w),
    .dist_o  (dist_w)
  );

  bsort_stage #(.N(N), .W(W), .SIGNED(SIGNED), .IW(IW), .SW(SW)) u_stage (
    .data_i  (mem_q),
    .stage_i (stage_w),
    .dist_i  (dist_w),
    .data_o  (net_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mem_q <= '0;
    else if (busy_w)     mem_q <= net_w;
    else if (wr_valid_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign busy_o    = busy_w;
  assign rd_data_o = busy_w ? '0 : mem_q[rd_idx_i];
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int IW = $clog2(N),
  parameter int SW = $clog2(IW + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  rd_data_o,
  input logic [SW-1:0] stage_w,
  input logic [SW-1:0] dist_w
);
  localparam int STEPS = IW * (IW + 1) / 2;
  localparam int CW    = $clog2(STEPS + 2);

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + CW'(1);
    else             run_cnt <= '0;
  end

  p_run_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == CW'(STEPS));
  p_run_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_cnt < CW'(STEPS));
  p_first_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (stage_w == SW'(1)) && (dist_w == '0));
  p_dist_below_stage_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> dist_w < stage_w);
  p_done_after_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  p_done_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rd_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rd_data_o == '0);
endmodule

bind bitonic_sort_engine bsort_chk #(.N(N), .W(W), .IW(IW), .SW(SW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rd_data_o (rd_data_o),
  .stage_w   (stage_w),
  .dist_w    (dist_w)
);

// File: tb/bitonic_sort_engine_tb.sv
`timescale 1ns/1ps
module bitonic_sort_engine_tb;
  localparam int N = 16, W = 8, IW = 4, STEPS = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, start = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [W-1:0]  wr_data = '0, rd_data;
  logic          busy, done;

  bitonic_sort_engine #(.N(N), .W(W), .SIGNED(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .start_i(start), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [W-1:0] vec [N];
  logic [W-1:0] ref_v [N];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load();
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      wr_valid = 1'b1; wr_idx = IW'(i); wr_data = vec[i];
    end
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic make_ref();
    for (int i = 0; i < N; i++) ref_v[i] = vec[i];
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N - 1 - a; b++)
        if ($signed(ref_v[b]) > $signed(ref_v[b+1])) begin
          logic [W-1:0] t;
          t = ref_v[b]; ref_v[b] = ref_v[b+1]; ref_v[b+1] = t;
        end
  endtask

  // mode bit0: start during run, bit1: write during run, bit2: read during run
  task automatic run_sort(input logic [2:0] mode);
    int cnt, guard;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cnt = 0; guard = 0;
    @(negedge clk);
    while (busy && guard < 1000) begin
      cnt++; guard++;
      if (mode[2]) begin
        rd_idx = IW'(cnt);
        #1 chk("R9 read blocked while busy", int'(rd_data), 0);
      end
      if (cnt == 3) begin
        start = mode[0];
        if (mode[1]) begin wr_valid = 1'b1; wr_idx = 4'd5; wr_data = 8'h55; end
      end else begin
        start = 1'b0; wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; wr_valid = 1'b0;
    chk("R3 busy cycle count", cnt, STEPS);
    chk("R4 done after last step", int'(done), 1);
    @(negedge clk);
    chk("R4 done single pulse", int'(done), 0);
    if (mode[0]) chk("R7 no second run", int'(busy), 0);
  endtask

  task automatic check_out(input string req);
    make_ref();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_idx = IW'(i);
      #1 chk(req, int'(rd_data), int'(ref_v[i]));
    end
  endtask

  task automatic sort_case(input string req, input logic [2:0] mode);
    load();
    run_sort(mode);
    check_out(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    for (int i = 0; i < N; i += 5) begin
      rd_idx = IW'(i);
      #1 chk("R1 buffer zero after reset", int'(rd_data), 0);
      @(negedge clk);
    end

    // R2 load and read back without sorting
    for (int i = 0; i < N; i++) vec[i] = W'(8'hA0 + i * 7);
    load();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_idx = IW'(i);
      #1 chk("R2 readback", int'(rd_data), int'(vec[i]));
    end

    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++) vec[i] = W'($urandom);
      sort_case("R5 random vector", 3'b000);
    end
    for (int i = 0; i < N; i++) vec[i] = W'(60 - i * 8);
    sort_case("R5 reversed vector", 3'b000);
    for (int i = 0; i < N; i++) vec[i] = W'(i * 3 - 20);
    sort_case("R5 presorted vector", 3'b000);
    for (int i = 0; i < N; i++) vec[i] = (i % 2 == 0) ? 8'h80 : 8'h7F;
    sort_case("R5 signed extremes", 3'b000);
    for (int i = 0; i < N; i++) vec[i] = 8'hE3;
    sort_case("R6 all equal keys", 3'b000);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) vec[i] = W'(int'($urandom_range(2)) - 1);
      sort_case("R6 duplicate heavy", 3'b000);
    end
    for (int i = 0; i < N; i++) vec[i] = W'($urandom);
    sort_case("R7 start while busy", 3'b001);
    for (int i = 0; i < N; i++) vec[i] = W'($urandom);
    sort_case("R8 write while busy", 3'b010);
    for (int i = 0; i < N; i++) vec[i] = W'($urandom);
    sort_case("R9 read while busy", 3'b100);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule